// File: doc/BRIEF.md
# Wear-Leveling Block Allocator

This block holds the logical-to-physical block map of a small flash array and, for every physical block, an erase count and a state: free, holding valid data, holding stale (invalid) data, or retired as bad. A controller sends it one request at a time. A host write asks for a fresh physical block for a logical block. The allocator never reuses the block now mapped. It picks the free block with the lowest erase count, repoints the map to that block and marks the old block stale. An erase request returns a stale block to the free pool and adds one to its count. When that count goes past the endurance limit, the block is retired to bad instead, and the other free blocks act as its spares.

A static leveling request takes a logical block that holds cold data and moves it onto the most-worn free block. This frees the low-wear block that held it for data that changes often. The move is refused unless the spread between the highest and lowest erase counts of the usable blocks is greater than a threshold set at an input pin.

Write and static requests scan the block table, one entry per clock. An erase goes straight to commit. Two read ports, each with one cycle of latency, show a map entry and a block's state.

Top module: `wl_alloc`

## Requirements
- R1: After reset, logical block i maps to physical block i. Physical blocks below NUM_LBLK are valid, the rest are free, every erase count is 0, req_ready is 1 and done is 0.
- R2: A write (req_op = 0) that finds a free block completes with done_err = 0. done_pblk is the free block with the lowest erase count, and on a tie the lowest index wins. Bad, valid and stale blocks are never chosen.
- R3: After a successful write, the map entry of req_lblk reads back as done_pblk, and the previously mapped block reads back as stale (free = 0, valid = 0, bad = 0).
- R4: An erase (req_op = 1) of a stale block completes with done_err = 0 and done_pblk = req_pblk. It adds one to the block's count and makes the block free. An erase of a free, valid or bad block sets done_err = 1 and changes no state.
- R5: An erase that raises a block's count above ENDURANCE marks that block bad (bad = 1, free = 0), and the block is never allocated again.
- R6: A write or static request that finds no free block sets done_err = 1. done_pblk then carries the current mapping of req_lblk, and the map is left unchanged.
- R7: A static request (req_op = 2) is carried out only when a free block exists and the highest minus the lowest erase count over all non-bad blocks is greater than gap_thr. It then moves req_lblk to the free block with the highest count (lowest index on a tie), and the old block becomes stale. Otherwise it sets done_err = 1 and changes nothing.
- R8: A request is taken when req_valid and req_ready are both 1, and req_ready stays 0 until done. done is a one-cycle pulse. For a write or static request it comes on the NUM_PBLK+1-th rising edge after acceptance; for an erase, or for the unused code req_op = 3, it comes on the first edge. Code 3 sets done_err = 1, reports the current mapping of req_lblk and changes nothing.
- R9: lkp_pblk shows the map entry of lkp_lblk one clock later. stat_cnt, stat_free, stat_valid and stat_bad show the state of stat_pblk one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator idle, can take a request |
| req_op | input | 2 | 0 write, 1 erase, 2 static move, 3 unused |
| req_lblk | input | $clog2(NUM_LBLK) | Logical block for write or static move |
| req_pblk | input | $clog2(NUM_PBLK) | Physical block for erase |
| gap_thr | input | CNT_W | Wear-spread threshold for static moves |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Request refused |
| done_pblk | output | $clog2(NUM_PBLK) | Chosen or addressed physical block |
| lkp_lblk | input | $clog2(NUM_LBLK) | Map lookup address |
| lkp_pblk | output | $clog2(NUM_PBLK) | Map lookup result |
| stat_pblk | input | $clog2(NUM_PBLK) | Block state lookup address |
| stat_cnt | output | CNT_W | Erase count of stat_pblk |
| stat_free | output | 1 | stat_pblk is free |
| stat_valid | output | 1 | stat_pblk holds valid data |
| stat_bad | output | 1 | stat_pblk is retired |

## Verification
The bench first goes after tie-breaking. After reset every free block has count 0, so a design that resolved ties toward the highest index, or took the last match of its scan, returns the wrong block on the very first write. The bench then runs the free pool dry and checks that the failed write leaves the map intact; a design that remapped anyway would point a logical block at a stale block. It also cycles one block through erases past the endurance limit: a design off by one in its compare retires the block one erase early or one erase late, and a design that forgot the bad flag hands the block out again. Finally it mixes erases of blocks that are not stale, static moves with thresholds just below and just above the wear spread, and random traffic, all compared against a bench model.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_ERASE = 2'd1, OP_STATIC = 2'd2, OP_NONE = 2'd3} wl_op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} wl_state_e;
  typedef struct packed {
    logic free;
    logic valid;
    logic bad;
  } blk_flags_t;
  localparam blk_flags_t FL_FREE  = 3'b100;
  localparam blk_flags_t FL_VALID = 3'b010;
  localparam blk_flags_t FL_STALE = 3'b000;
  localparam blk_flags_t FL_BAD   = 3'b001;
endpackage

// File: rtl/wl_tables.sv
module wl_tables
  import wl_pkg::*;
#(
  parameter int NUM_LBLK  = 4,
  parameter int NUM_PBLK  = 8,
  parameter int CNT_W     = 8,
  parameter int ENDURANCE = 5,
  localparam int LW = $clog2(NUM_LBLK),
  localparam int PW = $clog2(NUM_PBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  output blk_flags_t       rd_flags,
  input  logic [LW-1:0]    old_lblk,
  output logic [PW-1:0]    old_pblk,
  input  logic             alloc_en,
  input  logic [LW-1:0]    alloc_lblk,
  input  logic [PW-1:0]    alloc_pblk,
  input  logic             erase_en,
  input  logic [PW-1:0]    erase_pblk,
  input  logic [LW-1:0]    lkp_lblk,
  output logic [PW-1:0]    lkp_pblk,
  input  logic [PW-1:0]    stat_pblk,
  output logic [CNT_W-1:0] stat_cnt,
  output blk_flags_t       stat_flags
);
  logic [PW-1:0]    map_mem [NUM_LBLK];
  logic [CNT_W-1:0] cnt_mem [NUM_PBLK];
  blk_flags_t       flg_mem [NUM_PBLK];
  logic [CNT_W-1:0] next_cnt;

  assign rd_cnt   = cnt_mem[rd_idx];
  assign rd_flags = flg_mem[rd_idx];
  assign old_pblk = map_mem[old_lblk];
  assign next_cnt = cnt_mem[erase_pblk] + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LBLK; i++) map_mem[i] <= PW'(i);
      for (int p = 0; p < NUM_PBLK; p++) begin
        cnt_mem[p] <= '0;
        flg_mem[p] <= (p < NUM_LBLK) ? FL_VALID : FL_FREE;
      end
      lkp_pblk   <= '0;
      stat_cnt   <= '0;
      stat_flags <= FL_STALE;
    end else begin
      if (alloc_en) begin
        map_mem[alloc_lblk]          <= alloc_pblk;
        flg_mem[alloc_pblk]          <= FL_VALID;
        flg_mem[map_mem[alloc_lblk]] <= FL_STALE;
      end
      if (erase_en) begin
        cnt_mem[erase_pblk] <= next_cnt;
        flg_mem[erase_pblk] <= (int'(next_cnt) > ENDURANCE) ? FL_BAD : FL_FREE;
      end
      lkp_pblk   <= map_mem[lkp_lblk];
      stat_cnt   <= cnt_mem[stat_pblk];
      stat_flags <= flg_mem[stat_pblk];
    end
  end
endmodule

// File: rtl/wl_scan.sv
module wl_scan
  import wl_pkg::*;
#(
  parameter int NUM_PBLK = 8,
  parameter int CNT_W    = 8,
  localparam int PW = $clog2(NUM_PBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             want_max,
  input  logic [PW-1:0]    idx,
  input  logic [CNT_W-1:0] cnt,
  input  blk_flags_t       flags,
  output logic             found,
  output logic [PW-1:0]    best_idx,
  output logic [CNT_W-1:0] min_cnt,
  output logic [CNT_W-1:0] max_cnt
);
  logic [CNT_W-1:0] best_cnt;
  logic             seen;
  logic             better;

  assign better = flags.free && (!found || (want_max ? (cnt > best_cnt) : (cnt < best_cnt)));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      found    <= 1'b0;
      seen     <= 1'b0;
      best_idx <= '0;
      best_cnt <= '0;
      min_cnt  <= '0;
      max_cnt  <= '0;
    end else if (step) begin
      if (better) begin
        found    <= 1'b1;
        best_idx <= idx;
        best_cnt <= cnt;
      end
      if (!flags.bad) begin
        seen <= 1'b1;
        if (!seen || cnt < min_cnt) min_cnt <= cnt;
        if (!seen || cnt > max_cnt) max_cnt <= cnt;
      end
    end
  end
endmodule

// File: rtl/wl_alloc.sv
module wl_alloc
  import wl_pkg::*;
#(
  parameter int NUM_LBLK  = 4,
  parameter int NUM_PBLK  = 8,
  parameter int CNT_W     = 8,
  parameter int ENDURANCE = 5,
  localparam int LW = $clog2(NUM_LBLK),
  localparam int PW = $clog2(NUM_PBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [LW-1:0]    req_lblk,
  input  logic [PW-1:0]    req_pblk,
  input  logic [CNT_W-1:0] gap_thr,
  output logic             done,
  output logic             done_err,
  output logic [PW-1:0]    done_pblk,
  input  logic [LW-1:0]    lkp_lblk,
  output logic [PW-1:0]    lkp_pblk,
  input  logic [PW-1:0]    stat_pblk,
  output logic [CNT_W-1:0] stat_cnt,
  output logic             stat_free,
  output logic             stat_valid,
  output logic             stat_bad
);
  wl_state_e        state;
  wl_op_e           op_q;
  logic [LW-1:0]    lblk_q;
  logic [PW-1:0]    pblk_q;
  logic [PW-1:0]    idx_q;
  logic             accept;
  logic [PW-1:0]    rd_idx;
  logic [CNT_W-1:0] rd_cnt;
  blk_flags_t       rd_flags;
  blk_flags_t       stat_flags;
  logic [PW-1:0]    old_pblk;
  logic             found;
  logic [PW-1:0]    best_idx;
  logic [CNT_W-1:0] min_cnt, max_cnt;
  logic             gap_ok, do_alloc, erase_ok, in_commit;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_commit = (state == ST_COMMIT);
  assign rd_idx    = (state == ST_SCAN) ? idx_q : ((op_q == OP_ERASE) ? pblk_q : best_idx);
  assign gap_ok    = (max_cnt - min_cnt) > gap_thr;
  assign do_alloc  = in_commit && found &&
                     ((op_q == OP_WRITE) || ((op_q == OP_STATIC) && gap_ok));
  assign erase_ok  = in_commit && (op_q == OP_ERASE) && (rd_flags == FL_STALE);
  assign stat_free  = stat_flags.free;
  assign stat_valid = stat_flags.valid;
  assign stat_bad   = stat_flags.bad;

  wl_tables #(.NUM_LBLK(NUM_LBLK), .NUM_PBLK(NUM_PBLK), .CNT_W(CNT_W), .ENDURANCE(ENDURANCE)) u_tables (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt), .rd_flags(rd_flags),
    .old_lblk(lblk_q), .old_pblk(old_pblk),
    .alloc_en(do_alloc), .alloc_lblk(lblk_q), .alloc_pblk(best_idx),
    .erase_en(erase_ok), .erase_pblk(pblk_q),
    .lkp_lblk(lkp_lblk), .lkp_pblk(lkp_pblk),
    .stat_pblk(stat_pblk), .stat_cnt(stat_cnt), .stat_flags(stat_flags)
  );

  wl_scan #(.NUM_PBLK(NUM_PBLK), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst(rst), .clear(accept), .step(state == ST_SCAN),
    .want_max(op_q == OP_STATIC), .idx(idx_q), .cnt(rd_cnt), .flags(rd_flags),
    .found(found), .best_idx(best_idx), .min_cnt(min_cnt), .max_cnt(max_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_WRITE;
      lblk_q    <= '0;
      pblk_q    <= '0;
      idx_q     <= '0;
      done      <= 1'b0;
      done_err  <= 1'b0;
      done_pblk <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_q   <= wl_op_e'(req_op);
          lblk_q <= req_lblk;
          pblk_q <= req_pblk;
          idx_q  <= '0;
          state  <= (req_op == OP_WRITE || req_op == OP_STATIC) ? ST_SCAN : ST_COMMIT;
        end
        ST_SCAN: begin
          if (idx_q == PW'(NUM_PBLK - 1)) state <= ST_COMMIT;
          else idx_q <= idx_q + PW'(1);
        end
        default: begin
          done      <= 1'b1;
          done_err  <= !(do_alloc || erase_ok);
          done_pblk <= do_alloc ? best_idx : ((op_q == OP_ERASE) ? pblk_q : old_pblk);
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/wl_alloc_chk.sv
module wl_alloc_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic done_err,
  input logic do_alloc,
  input logic erase_ok,
  input logic same_blk,
  input logic tgt_free
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_target_free_r2: assert property (@(posedge clk) disable iff (rst) do_alloc |-> tgt_free);
  p_not_in_place_r3: assert property (@(posedge clk) disable iff (rst) do_alloc |-> !same_blk);
  p_alloc_reports_ok_r2: assert property (@(posedge clk) disable iff (rst)
    do_alloc |=> (done && !done_err));
  p_erase_reports_ok_r4: assert property (@(posedge clk) disable iff (rst)
    erase_ok |=> (done && !done_err));
  p_refusal_no_change_r6: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> !$past(do_alloc || erase_ok));
endmodule

bind wl_alloc wl_alloc_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_err(done_err), .do_alloc(do_alloc), .erase_ok(erase_ok),
  .same_blk(best_idx == old_pblk), .tgt_free(rd_flags.free)
);

// File: tb/wl_alloc_tb.sv
module wl_alloc_tb;
  localparam int NL = 4, NP = 8, CW = 8, ENDUR = 5;
  localparam int LW = $clog2(NL), PW = $clog2(NP);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [LW-1:0] req_lblk = '0, lkp_lblk = '0;
  logic [PW-1:0] req_pblk = '0, stat_pblk = '0, done_pblk, lkp_pblk;
  logic [CW-1:0] gap_thr = '0, stat_cnt;
  logic done, done_err, stat_free, stat_valid, stat_bad;

  always #2 clk = ~clk;

  wl_alloc #(.NUM_LBLK(NL), .NUM_PBLK(NP), .CNT_W(CW), .ENDURANCE(ENDUR)) u_dut (.*);

  int checks = 0, errors = 0;
  int m_map[NL];
  int m_cnt[NP];
  bit m_free[NP], m_valid[NP], m_bad[NP];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_free(input bit want_max);
    int best = -1;
    for (int p = 0; p < NP; p++)
      if (m_free[p] && (best < 0 || (want_max ? m_cnt[p] > m_cnt[best] : m_cnt[p] < m_cnt[best])))
        best = p;
    return best;
  endfunction

  function automatic int wear_gap();
    int lo = -1, hi = -1;
    for (int p = 0; p < NP; p++)
      if (!m_bad[p]) begin
        if (lo < 0 || m_cnt[p] < lo) lo = m_cnt[p];
        if (hi < 0 || m_cnt[p] > hi) hi = m_cnt[p];
      end
    return (lo < 0) ? 0 : hi - lo;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NL; i++) m_map[i] = i;
    for (int p = 0; p < NP; p++) begin
      m_cnt[p] = 0; m_free[p] = (p >= NL); m_valid[p] = (p < NL); m_bad[p] = 0;
    end
  endtask

  task automatic peek(input int l, input int p);
    @(negedge clk);
    lkp_lblk = LW'(l); stat_pblk = PW'(p);
    @(negedge clk);
  endtask

  task automatic check_tables(input string tag);
    for (int p = 0; p < NP; p++) begin
      peek(p % NL, p);
      chk(int'(lkp_pblk) == m_map[p % NL], tag, lkp_pblk, m_map[p % NL]);
      chk(int'(stat_cnt) == m_cnt[p], tag, stat_cnt, m_cnt[p]);
      chk({stat_free, stat_valid, stat_bad} == {m_free[p], m_valid[p], m_bad[p]}, tag,
          {stat_free, stat_valid, stat_bad}, {m_free[p], m_valid[p], m_bad[p]});
    end
  endtask

  task automatic do_req(input int op, input int l, input int p, input int thr);
    int t, exp_pblk, n, old;
    bit exp_err, scan;
    string tag;
    old  = m_map[l];
    scan = (op == 0 || op == 2);
    if (op == 0) begin
      t = find_free(1'b0); exp_err = (t < 0); tag = exp_err ? "R6" : "R2";
    end else if (op == 2) begin
      t = find_free(1'b1); exp_err = (t < 0) || (wear_gap() <= thr);
      tag = (t < 0) ? "R6" : "R7";
    end else if (op == 1) begin
      t = -1; exp_err = m_free[p] || m_valid[p] || m_bad[p];
      tag = (!exp_err && m_cnt[p] + 1 > ENDUR) ? "R5" : "R4";
    end else begin
      t = -1; exp_err = 1'b1; tag = "R8";
    end
    exp_pblk = (op == 1) ? p : (exp_err ? old : t);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", req_ready, 1);
    req_valid = 1'b1; req_op = 2'(op); req_lblk = LW'(l); req_pblk = PW'(p); gap_thr = CW'(thr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", req_ready, 0);
    n = 1;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == (scan ? NP + 2 : 2), "R8", n, scan ? NP + 2 : 2);
    chk(done_err == exp_err, tag, done_err, exp_err);
    chk(int'(done_pblk) == exp_pblk, tag, done_pblk, exp_pblk);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
    if (!exp_err) begin
      if (scan) begin
        m_valid[old] = 0; m_free[t] = 0; m_valid[t] = 1; m_map[l] = t;
        peek(l, old);
        chk(int'(lkp_pblk) == t, "R3", lkp_pblk, t);
        chk({stat_free, stat_valid, stat_bad} == 3'b000, "R3", {stat_free, stat_valid, stat_bad}, 0);
      end else begin
        m_cnt[p]++;
        if (m_cnt[p] > ENDUR) m_bad[p] = 1; else m_free[p] = 1;
        peek(0, p);
        chk(stat_bad == m_bad[p], tag, stat_bad, m_bad[p]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int stale[$];
    int op, l, p;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", {req_ready, done}, 2'b10);
    check_tables("R1");

    do_req(0, 0, 0, 0);            // tie among zero counts: block 4
    do_req(1, 0, 0, 0);            // erase stale block 0
    do_req(1, 0, 1, 0);            // erase of a valid block is refused
    do_req(0, 1, 0, 0);            // lowest count wins: block 5
    do_req(2, 2, 0, 1);            // spread 1 not above 1: refused
    do_req(2, 2, 0, 0);            // spread 1 above 0: moves to block 0
    do_req(3, 3, 0, 0);            // unused code
    for (int k = 0; k < 6; k++) do_req(0, k % NL, 0, 0);   // drains the free pool
    check_tables("R6");
    for (int q = 0; q < NP; q++) if (!m_free[q] && !m_valid[q] && !m_bad[q]) do_req(1, 0, q, 0);
    for (int k = 0; k < 2 * (ENDUR + 2); k++) begin       // wears blocks out
      old_erase: begin
        int prev = m_map[2];
        do_req(0, 2, 0, 0);
        do_req(1, 0, prev, 0);
      end
    end
    check_tables("R5");

    for (int k = 0; k < 300; k++) begin
      op = $urandom % 8;
      l  = $urandom % NL;
      p  = $urandom % NP;
      stale.delete();
      for (int q = 0; q < NP; q++) if (!m_free[q] && !m_valid[q] && !m_bad[q]) stale.push_back(q);
      if (op < 3) do_req(0, l, p, 0);
      else if (op < 6) begin
        if (stale.size() > 0 && ($urandom % 4) != 0) p = stale[$urandom % stale.size()];
        do_req(1, l, p, 0);
      end else if (op == 6) do_req(2, l, p, $urandom % 4);
      else do_req(3, l, p, 0);
      if (k % 25 == 24) check_tables("R9");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule